// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

The block counts time in two stages. A small prescaler down counter divides a count source, and each time it runs out it advances an 8-bit main down counter. When the main counter runs out, the block raises a one-cycle interrupt request. Software writes three registers through one strobe each: the prescaler start value, the main start value, and a control byte. A separate read strobe captures the main counter's current value into a holding register that the read data port shows.

The count source comes from one of four modes that share a single input pin. The pin is passed through a two-stage synchronizer before any edge detection. The main counter either reloads and keeps running when it reaches terminal count, or it stops there.

- Internal mode counts the core clock divided by four.
- External mode counts falling edges of the pin.
- Gated mode counts the divided clock only while the pin is high.
- Triggered mode waits for a falling edge of the pin, then reloads and starts.

Top module: `ptim_top`

## Requirements
- R1: After reset `irq` is low, `rdata` is 0 and the main counter holds 0, so a read strobe with no start also returns 0.
- R2: Control byte layout: bit 0 is start (1 loads both counters from their start values, 0 stops), bit 1 is continuous, and bits 3:2 select the mode (0 internal, 1 external, 2 gated, 3 triggered). In internal mode the first count step happens 4 clocks after the starting write and then every 4 clocks. `irq` rises in the cycle after the edge that completes prescaler × main count steps, which is 4·P·C clocks after the start write edge.
- R3: A prescaler start value of 0 divides by 64.
- R4: A main start value of 0 gives 256 main counts.
- R5: With continuous set, the main counter reloads from its start value at terminal count, and `irq` repeats every 4·P·C clocks.
- R6: With continuous clear, the counter stops at 0 after terminal count, and no further `irq` follows.
- R7: A one-cycle `rd_cnt` strobe captures the main count present in that cycle. `rdata` holds that value until the next strobe, even while counting goes on.
- R8: In external mode, each falling edge of the synchronized `tin` is one count step.
- R9: In gated mode, divided-clock steps are counted only while the synchronized `tin` is high.
- R10: In triggered mode, a start write loads the counters but no counting takes place until a falling edge of `tin`. That edge reloads the counters and starts counting.
- R11: Writing a new start value while the timer runs leaves the current count untouched. The new value takes effect at the next reload.
- R12: `irq` is never high for two cycles in a row.
- R13: Writing start = 0 halts counting, and the main count then stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tin | input | 1 | Timer pin: external clock, gate or trigger |
| wr_pre | input | 1 | Write strobe for the prescaler start value (`wdata[5:0]`) |
| wr_cnt | input | 1 | Write strobe for the main start value (`wdata[7:0]`) |
| wr_ctl | input | 1 | Write strobe for the control byte |
| wdata | input | 8 | Write data |
| rd_cnt | input | 1 | Read strobe that captures the current main count |
| rdata | output | 8 | Captured main count |
| irq | output | 1 | Terminal-count interrupt pulse |

## Verification
The bench builds the block with its default widths: a 6-bit prescaler, an 8-bit main counter, a divide-by-4 internal clock and two synchronizer stages. Because the divider is only four, both wrap-to-maximum cases are short runs: a prescaler of 64 finishes in 256 clocks, and a main count of 256 finishes in 1024 clocks. Internal-mode interrupts are predicted to the exact cycle and checked through a queue. Interrupts in the pin-driven modes are counted and cross-checked against captured counter values.

// File: rtl/ptim_pkg.sv
package ptim_pkg;

    typedef enum logic [1:0] {
        CK_INT  = 2'd0,
        CK_EXT  = 2'd1,
        CK_GATE = 2'd2,
        CK_TRIG = 2'd3
    } ck_mode_e;

    typedef struct packed {
        ck_mode_e mode;
        logic     cont;
        logic     arm;
    } ctl_t;

    localparam int CTL_BITS = 4;

    function automatic ctl_t decode_ctl(input logic [CTL_BITS-1:0] w);
        ctl_t d;
        d.arm  = w[0];
        d.cont = w[1];
        d.mode = ck_mode_e'(w[3:2]);
        return d;
    endfunction

    function automatic logic runs_on_start(input ck_mode_e m);
        return m != CK_TRIG;
    endfunction

endpackage

// File: rtl/ptim_pin_sync.sv
module ptim_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic fall
);
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-1:0], pin};
    end

    assign level = chain[SYNC_STAGES-1];
    assign fall  = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall); // R8
endmodule

// File: rtl/ptim_tick_sel.sv
module ptim_tick_sel
    import ptim_pkg::*;
#(
    parameter int INT_DIV = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  ck_mode_e mode,
    input  logic     pin_level,
    input  logic     pin_fall,
    output logic     tick
);
    localparam int DIV_W = (INT_DIV > 2) ? $clog2(INT_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INT_DIV - 1);
    localparam logic [DIV_W-1:0] DIV_ONE  = DIV_W'(1);

    logic [DIV_W-1:0] div_q;
    logic             int_tick;

    always_ff @(posedge clk) begin
        if (rst || clear)          div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                        div_q <= div_q + DIV_ONE;
    end

    assign int_tick = (div_q == DIV_LAST);

    always_comb begin
        case (mode)
            CK_EXT:  tick = pin_fall;
            CK_GATE: tick = int_tick & pin_level;
            default: tick = int_tick;
        endcase
    end

    AST_DIV_SPACING: assert property (@(posedge clk) disable iff (rst)
        int_tick |=> !int_tick); // R2
endmodule

// File: rtl/ptim_down_stage.sv
module ptim_down_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         en,
    input  logic         wrap,
    input  logic [W-1:0] init,
    output logic [W-1:0] value,
    output logic         term
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (rst)                        val_q <= '0;
        else if (load)                  val_q <= init;
        else if (en) begin
            if (val_q == ONE && wrap)   val_q <= init;
            else                        val_q <= val_q - ONE;
        end
    end

    assign value = val_q;
    assign term  = en & ~load & (val_q == ONE);

    AST_RELOAD_AT_END: assert property (@(posedge clk) disable iff (rst)
        (en && !load && val_q == ONE && wrap) |=> (val_q == $past(init))); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> $stable(val_q)); // R13
endmodule

// File: rtl/ptim_top.sv
module ptim_top
    import ptim_pkg::*;
#(
    parameter int PRE_W       = 6,
    parameter int CNT_W       = 8,
    parameter int DATA_W      = 8,
    parameter int INT_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tin,
    input  logic              wr_pre,
    input  logic              wr_cnt,
    input  logic              wr_ctl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_cnt,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq
);
    logic [PRE_W-1:0] pre_init_q;
    logic [CNT_W-1:0] cnt_init_q;
    ctl_t             ctl_q, new_ctl;
    logic             running_q, irq_q;
    logic [CNT_W-1:0] rdata_q;

    logic             pin_level, pin_fall, tick;
    logic             start_wr, trig_fire, load_all, tick_en;
    logic [PRE_W-1:0] pre_val;
    logic [CNT_W-1:0] main_val;
    logic             pre_term, main_term;

    assign new_ctl   = decode_ctl(wdata[CTL_BITS-1:0]);
    assign start_wr  = wr_ctl & new_ctl.arm;
    assign trig_fire = ~wr_ctl & ctl_q.arm & (ctl_q.mode == CK_TRIG) & pin_fall;
    assign load_all  = start_wr | trig_fire;
    assign tick_en   = running_q & tick & ~load_all;

    ptim_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin(tin), .level(pin_level), .fall(pin_fall)
    );

    ptim_tick_sel #(.INT_DIV(INT_DIV)) u_tick (
        .clk(clk), .rst(rst), .clear(load_all), .mode(ctl_q.mode),
        .pin_level(pin_level), .pin_fall(pin_fall), .tick(tick)
    );

    ptim_down_stage #(.W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .load(load_all), .en(tick_en), .wrap(1'b1),
        .init(pre_init_q), .value(pre_val), .term(pre_term)
    );

    ptim_down_stage #(.W(CNT_W)) u_main (
        .clk(clk), .rst(rst), .load(load_all), .en(pre_term), .wrap(ctl_q.cont),
        .init(cnt_init_q), .value(main_val), .term(main_term)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_init_q <= '0;
            cnt_init_q <= '0;
            ctl_q      <= '0;
            running_q  <= 1'b0;
            irq_q      <= 1'b0;
            rdata_q    <= '0;
        end else begin
            if (wr_pre) pre_init_q <= wdata[PRE_W-1:0];
            if (wr_cnt) cnt_init_q <= wdata[CNT_W-1:0];
            if (wr_ctl) begin
                ctl_q     <= new_ctl;
                running_q <= new_ctl.arm & runs_on_start(new_ctl.mode);
            end else if (trig_fire) begin
                running_q <= 1'b1;
            end else if (main_term && !ctl_q.cont) begin
                running_q <= 1'b0;
            end
            irq_q <= main_term;
            if (rd_cnt) rdata_q <= main_val;
        end
    end

    assign rdata = rdata_q;
    assign irq   = irq_q;

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q); // R12
    AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !ctl_q.cont && !$past(wr_ctl) && ctl_q.mode != CK_TRIG)
            |-> (!running_q && main_val == '0)); // R6
    AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_cnt) |-> $stable(rdata_q)); // R7
    AST_TRIG_WAITS: assert property (@(posedge clk) disable iff (rst)
        ($past(start_wr) && ctl_q.mode == CK_TRIG) |-> !running_q); // R10
endmodule

// File: tb/ptim_top_tb_top.sv
`timescale 1ns/1ps
module ptim_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tin = 1'b1;
    logic       wr_pre = 1'b0, wr_cnt = 1'b0, wr_ctl = 1'b0, rd_cnt = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int irq_seen = 0;
    bit sb_strict = 1'b0;
    bit finished  = 1'b0;
    string sb_tag = "R2";
    int exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ptim_top dut_i (
        .clk(clk), .rst(rst), .tin(tin), .wr_pre(wr_pre), .wr_cnt(wr_cnt),
        .wr_ctl(wr_ctl), .wdata(wdata), .rd_cnt(rd_cnt), .rdata(rdata), .irq(irq)
    );

    // monitor: pops the expected irq cycle and compares
    always @(negedge clk) begin
        if (!rst && irq) begin
            irq_seen = irq_seen + 1;
            if (sb_strict) begin
                n_checks = n_checks + 1;
                if (exp_q.size() == 0) begin
                    n_fail = n_fail + 1;
                    $display("FAIL %s: unexpected irq at cycle %0d (expected none)", sb_tag, cyc);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (e != cyc) begin
                        n_fail = n_fail + 1;
                        $display("FAIL %s: irq at cycle %0d, expected %0d", sb_tag, cyc, e);
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_wr(input int which, input logic [7:0] v);
        wdata = v;
        if (which == 0) wr_pre = 1'b1;
        else if (which == 1) wr_cnt = 1'b1;
        else wr_ctl = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_pre = 1'b0; wr_cnt = 1'b0; wr_ctl = 1'b0;
    endtask

    function automatic logic [7:0] ctl_byte(input int mode, input bit cont, input bit arm);
        return {4'b0, 2'(mode), cont, arm};
    endfunction

    task automatic do_read(output int v);
        rd_cnt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_cnt = 1'b0;
        v = int'(rdata);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // driver: programs the timer, starts it, and pushes expected irq cycles
    task automatic start_int(input int p, input int c, input bit cont, input int n_irq, output int l);
        int pe, ce;
        pulse_wr(0, 8'(p));
        pulse_wr(1, 8'(c));
        pulse_wr(2, ctl_byte(0, cont, 1'b1));
        l = cyc;
        pe = (p == 0) ? 64 : p;
        ce = (c == 0) ? 256 : c;
        for (int k = 1; k <= n_irq; k++) exp_q.push_back(l + 4 * pe * ce * k);
    endtask

    task automatic drain_check(input string tag);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        finished = 1'b1;
        $finish;
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        int l, v, v2, base;
        idle(4);
        rst = 1'b0;
        idle(2);

        // R1: reset state
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);
        chk(rdata == 8'd0, "R1 rdata", int'(rdata), 0);
        do_read(v);
        chk(v == 0, "R1 count after reset", v, 0);

        // R2 / R5: internal mode, continuous, exact irq times
        sb_strict = 1'b1; sb_tag = "R5";
        start_int(3, 2, 1'b1, 3, l);
        wait_until(l + 80);
        pulse_wr(2, ctl_byte(0, 1'b0, 1'b0));
        idle(40);
        drain_check("R5 all continuous irqs seen");

        // R13: stopped count is frozen
        do_read(v);
        idle(30);
        do_read(v2);
        chk(v == v2, "R13 count frozen after stop", v2, v);

        // R7 / R6 / R2: single pass, snapshot read
        sb_tag = "R6";
        start_int(1, 10, 1'b0, 1, l);
        wait_until(l + 13);
        do_read(v);
        chk(v == 7, "R7 snapshot after three steps", v, 7);
        idle(20);
        chk(rdata == 8'd7, "R7 rdata held without strobe", int'(rdata), 7);
        wait_until(l + 60);
        do_read(v);
        chk(v == 0, "R6 count stops at zero", v, 0);
        idle(100);
        drain_check("R6 single irq only");

        // R11 / R5: start value rewritten while running
        sb_tag = "R11";
        pulse_wr(0, 8'd1);
        pulse_wr(1, 8'd5);
        pulse_wr(2, ctl_byte(0, 1'b1, 1'b1));
        l = cyc;
        exp_q.push_back(l + 20);
        exp_q.push_back(l + 56);
        pulse_wr(1, 8'd9);
        wait_until(l + 9);
        do_read(v);
        chk(v == 3, "R11 running count unchanged by write", v, 3);
        wait_until(l + 60);
        pulse_wr(2, ctl_byte(0, 1'b0, 1'b0));
        idle(10);
        drain_check("R11 reload uses new value");

        // R3: prescaler 0 means 64
        sb_tag = "R3";
        start_int(0, 1, 1'b0, 1, l);
        wait_until(l + 300);
        drain_check("R3 divide by 64");

        // R4: main 0 means 256
        sb_tag = "R4";
        start_int(1, 0, 1'b0, 1, l);
        wait_until(l + 1100);
        drain_check("R4 256 counts");
        sb_strict = 1'b0;

        // R9: gated mode
        tin = 1'b0;
        idle(6);
        pulse_wr(0, 8'd1);
        pulse_wr(1, 8'd4);
        base = irq_seen;
        pulse_wr(2, ctl_byte(2, 1'b0, 1'b1));
        idle(40);
        do_read(v);
        chk(v == 4, "R9 no count while pin low", v, 4);
        tin = 1'b1;
        idle(40);
        chk(irq_seen - base == 1, "R9 counts while pin high", irq_seen - base, 1);
        do_read(v);
        chk(v == 0, "R9 count finished", v, 0);

        // R8: external mode
        pulse_wr(1, 8'd3);
        base = irq_seen;
        pulse_wr(2, ctl_byte(1, 1'b0, 1'b1));
        for (int i = 0; i < 2; i++) begin
            tin = 1'b0; idle(4);
            tin = 1'b1; idle(4);
        end
        idle(6);
        do_read(v);
        chk(v == 1, "R8 two pin falls counted", v, 1);
        tin = 1'b0; idle(4);
        tin = 1'b1; idle(10);
        chk(irq_seen - base == 1, "R8 irq after third fall", irq_seen - base, 1);

        // R10: triggered mode
        pulse_wr(1, 8'd2);
        base = irq_seen;
        pulse_wr(2, ctl_byte(3, 1'b0, 1'b1));
        idle(40);
        do_read(v);
        chk(v == 2, "R10 waits for trigger", v, 2);
        chk(irq_seen == base, "R10 no irq before trigger", irq_seen - base, 0);
        tin = 1'b0;
        idle(30);
        chk(irq_seen - base == 1, "R10 irq after trigger", irq_seen - base, 1);
        do_read(v);
        chk(v == 0, "R10 count after trigger", v, 0);
        tin = 1'b1;
        idle(10);

        finish_run();
    end
endmodule